// File: doc/BRIEF.md
# Hard-Decision LDPC Node Processor Pair

This block holds one check-node processor and one variable-node processor for iterative hard-decision decoding of a low-density parity-check code over a binary symmetric channel. Each processor turns its incoming edge messages into outgoing messages. Every outgoing message is extrinsic: the message on an edge is computed without using the message that arrived on that same edge. The surrounding decoder routes the edges between many such pairs. It also supplies the iteration strobe and the frame load.

The check node returns, on each edge, the parity of all its other inputs. The variable node stores the channel bit when a frame is loaded. On each iteration it sends that bit back out on every edge, except where enough of the other edges disagree with it; in that case it sends the inverted bit. The required amount of disagreement comes from one of two rules:
- A unanimity rule, where all other edges must disagree.
- A counting rule, where the threshold is given on an input.

The variable node also keeps a running majority decision. All outputs are registered and change only on a load or an iteration strobe.

Top module: `bitflipNodePair`

## Requirements
- R1: A synchronous active-high `rst` clears `chkOut`, `varOut`, `decision` and the stored channel bit to 0 at the next rising edge.
- R2: When `initLoad` is 1 at a rising edge, every bit of `varOut` and `decision` take the value of `chanBit`, and the stored channel bit takes that value as well. `chkOut` keeps its value. A load has priority over `iterStrobe` in the same cycle.
- R3: On an iteration (`iterStrobe`=1, `initLoad`=0), bit k of `chkOut` becomes the XOR of every bit of `chkIn` except bit k. Bit k of each bus is edge k.
- R4: With `useRuleB`=0 on an iteration, bit k of `varOut` becomes the inverted stored channel bit only if all VAR_DEG-1 other bits of `varIn` differ from the stored channel bit. Otherwise it becomes the stored channel bit.
- R5: With `useRuleB`=1 on an iteration, bit k of `varOut` becomes the inverted stored channel bit when the number of bits of `varIn` other than bit k that differ from the stored bit is at least `flipThresh`. Otherwise it becomes the stored bit.
- R6: With `useRuleB`=1 and `flipThresh` greater than VAR_DEG-1, no bit of `varOut` ever differs from the stored channel bit.
- R7: With `useRuleB`=1, a `flipThresh` of 0 behaves exactly as a threshold of 1.
- R8: On an iteration, `decision` becomes the majority among the stored channel bit and all VAR_DEG bits of `varIn`. A tie goes to the stored channel bit.
- R9: In a cycle with neither `initLoad` nor `iterStrobe`, all outputs hold, whatever the other inputs do. `chanBit` affects nothing except at a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iterStrobe | input | 1 | Perform one decoding iteration |
| initLoad | input | 1 | Load the channel bit at the start of a frame |
| chanBit | input | 1 | Received hard channel bit |
| useRuleB | input | 1 | 0 = unanimity rule, 1 = counting rule |
| flipThresh | input | THR_W | Threshold for the counting rule |
| chkIn | input | CHK_DEG | Variable-to-check messages into the check node |
| chkOut | output | CHK_DEG | Extrinsic parity messages out of the check node |
| varIn | input | VAR_DEG | Check-to-variable messages into the variable node |
| varOut | output | VAR_DEG | Extrinsic messages out of the variable node |
| decision | output | 1 | Majority hard decision of the variable node |

## Verification
Each result sits exactly one register behind its stimulus:
- A load, an iteration or a reset sampled at a rising edge is visible right after that edge.
- A cycle with no strobe leaves every output as it was.

The bench drives its inputs on the falling edge. It keeps a behavioural model that advances on the same rising edge as the design, and compares every output on the following falling edge. Each comparison therefore covers exactly one edge's worth of effect. The scrambled inputs in idle cycles must show no change at that same point.

// File: rtl/bfNodePkg.sv
package bfNodePkg;
  typedef struct packed {
    logic loadInit;
    logic stepUpd;
  } nodeCtlT;
endpackage

// File: rtl/nodeCtl.sv
module nodeCtl
  import bfNodePkg::*;
(
  input  logic    iterStrobe,
  input  logic    initLoad,
  output nodeCtlT ctl
);
  always_comb begin
    ctl.loadInit = initLoad;
    ctl.stepUpd  = iterStrobe & ~initLoad;
  end
endmodule

// File: rtl/chkNodeDp.sv
module chkNodeDp
  import bfNodePkg::*;
#(
  parameter int CHK_DEG = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  nodeCtlT            ctl,
  input  logic [CHK_DEG-1:0] chkIn,
  output logic [CHK_DEG-1:0] chkOut
);
  localparam logic OUT_PAR_ODD = ((CHK_DEG - 1) % 2) == 1;

  logic               allPar;
  logic [CHK_DEG-1:0] nextMsg;

  assign allPar = ^chkIn;

  for (genvar k = 0; k < CHK_DEG; k++) begin : g_edge
    assign nextMsg[k] = allPar ^ chkIn[k];
  end

  always_ff @(posedge clk) begin
    if (rst) chkOut <= '0;
    else if (ctl.stepUpd) chkOut <= nextMsg;
  end

  // R3: parity over all outputs follows from input parity and degree
  p_out_parity_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.stepUpd |=> (^chkOut) == (OUT_PAR_ODD & $past(^chkIn)));

  // R9: no strobe, no change
  p_chk_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl.stepUpd |=> $stable(chkOut));
endmodule

// File: rtl/varNodeDp.sv
module varNodeDp
  import bfNodePkg::*;
#(
  parameter int VAR_DEG = 3,
  parameter int THR_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  nodeCtlT            ctl,
  input  logic               chanBit,
  input  logic               useRuleB,
  input  logic [THR_W-1:0]   flipThresh,
  input  logic [VAR_DEG-1:0] varIn,
  output logic [VAR_DEG-1:0] varOut,
  output logic               decision
);
  localparam int UNANIMOUS = VAR_DEG - 1;
  localparam int VOTERS    = VAR_DEG + 1;

  logic               xiReg;
  logic [VAR_DEG-1:0] disagree;
  logic [VAR_DEG-1:0] nextMsg;
  logic               nextDec;
  int                 effThr;

  assign disagree = varIn ^ {VAR_DEG{xiReg}};

  always_comb begin
    if (!useRuleB) effThr = UNANIMOUS;
    else if (flipThresh == '0) effThr = 1;
    else effThr = int'(flipThresh);
  end

  for (genvar k = 0; k < VAR_DEG; k++) begin : g_edge
    int otherCnt;
    always_comb begin
      otherCnt = 0;
      for (int j = 0; j < VAR_DEG; j++)
        if (j != k && disagree[j]) otherCnt = otherCnt + 1;
    end
    assign nextMsg[k] = (otherCnt >= effThr) ? ~xiReg : xiReg;
  end

  always_comb begin
    int ones;
    ones = xiReg ? 1 : 0;
    for (int j = 0; j < VAR_DEG; j++)
      if (varIn[j]) ones = ones + 1;
    if (2 * ones > VOTERS) nextDec = 1'b1;
    else if (2 * ones < VOTERS) nextDec = 1'b0;
    else nextDec = xiReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xiReg    <= 1'b0;
      varOut   <= '0;
      decision <= 1'b0;
    end else if (ctl.loadInit) begin
      xiReg    <= chanBit;
      varOut   <= {VAR_DEG{chanBit}};
      decision <= chanBit;
    end else if (ctl.stepUpd) begin
      varOut   <= nextMsg;
      decision <= nextDec;
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.loadInit |=> (varOut == {VAR_DEG{$past(chanBit)}}) && (decision == $past(chanBit)));

  p_agree_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl.stepUpd && !useRuleB && varIn == {VAR_DEG{xiReg}})
      |=> varOut == {VAR_DEG{$past(xiReg)}});

  p_never_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.stepUpd && useRuleB && int'(flipThresh) > UNANIMOUS)
      |=> varOut == {VAR_DEG{$past(xiReg)}});

  p_var_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctl.stepUpd && !ctl.loadInit) |=> $stable(varOut) && $stable(decision));
endmodule

// File: rtl/bitflipNodePair.sv
module bitflipNodePair
  import bfNodePkg::*;
#(
  parameter int CHK_DEG = 6,
  parameter int VAR_DEG = 3,
  parameter int THR_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               iterStrobe,
  input  logic               initLoad,
  input  logic               chanBit,
  input  logic               useRuleB,
  input  logic [THR_W-1:0]   flipThresh,
  input  logic [CHK_DEG-1:0] chkIn,
  output logic [CHK_DEG-1:0] chkOut,
  input  logic [VAR_DEG-1:0] varIn,
  output logic [VAR_DEG-1:0] varOut,
  output logic               decision
);
  nodeCtlT ctl;

  nodeCtl u_ctl (
    .iterStrobe (iterStrobe),
    .initLoad   (initLoad),
    .ctl        (ctl)
  );

  chkNodeDp #(.CHK_DEG(CHK_DEG)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .chkIn  (chkIn),
    .chkOut (chkOut)
  );

  varNodeDp #(.VAR_DEG(VAR_DEG), .THR_W(THR_W)) u_var (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .chanBit    (chanBit),
    .useRuleB   (useRuleB),
    .flipThresh (flipThresh),
    .varIn      (varIn),
    .varOut     (varOut),
    .decision   (decision)
  );
endmodule

// File: tb/bitflipNodePair_bench.sv
`timescale 1ns/1ps
module bitflipNodePair_bench;
  localparam int CD = 6;
  localparam int VD = 3;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iterStrobe = 1'b0;
  logic          initLoad = 1'b0;
  logic          chanBit = 1'b0;
  logic          useRuleB = 1'b0;
  logic [TW-1:0] flipThresh = '0;
  logic [CD-1:0] chkIn = '0;
  logic [CD-1:0] chkOut;
  logic [VD-1:0] varIn = '0;
  logic [VD-1:0] varOut;
  logic          decision;

  int compared = 0;
  int mismatched = 0;
  string tagNow = "R1";

  logic [CD-1:0] mChk = '0;
  logic [VD-1:0] mVar = '0;
  logic          mDec = 1'b0;
  logic          mXi = 1'b0;

  always #2.5 clk = ~clk;

  bitflipNodePair #(.CHK_DEG(CD), .VAR_DEG(VD), .THR_W(TW)) u_bitflipNodePair (
    .clk(clk), .rst(rst), .iterStrobe(iterStrobe), .initLoad(initLoad),
    .chanBit(chanBit), .useRuleB(useRuleB), .flipThresh(flipThresh),
    .chkIn(chkIn), .chkOut(chkOut), .varIn(varIn), .varOut(varOut),
    .decision(decision)
  );

  // behavioural reference, advanced on the same edge as the design
  always @(posedge clk) begin
    if (rst) begin
      mChk = '0; mVar = '0; mDec = 1'b0; mXi = 1'b0;
    end else if (initLoad) begin
      mXi = chanBit;
      mVar = {VD{chanBit}};
      mDec = chanBit;
    end else if (iterStrobe) begin
      int thr;
      int ones;
      for (int k = 0; k < CD; k++) begin
        int par;
        par = 0;
        for (int j = 0; j < CD; j++) if (j != k) par = par ^ int'(chkIn[j]);
        mChk[k] = par[0];
      end
      thr = !useRuleB ? VD - 1 : (flipThresh == 0 ? 1 : int'(flipThresh));
      for (int k = 0; k < VD; k++) begin
        int cnt;
        cnt = 0;
        for (int j = 0; j < VD; j++) if (j != k && varIn[j] != mXi) cnt++;
        mVar[k] = (cnt >= thr) ? ~mXi : mXi;
      end
      ones = int'(mXi);
      for (int j = 0; j < VD; j++) ones += int'(varIn[j]);
      mDec = (2 * ones > VD + 1) ? 1'b1 : (2 * ones < VD + 1) ? 1'b0 : mXi;
    end
  end

  task automatic compareNow();
    compared++;
    if (chkOut !== mChk || varOut !== mVar || decision !== mDec) begin
      mismatched++;
      $display("FAIL %s: got chk=%b var=%b dec=%b expected chk=%b var=%b dec=%b",
               tagNow, chkOut, varOut, decision, mChk, mVar, mDec);
    end
  endtask

  task automatic step(input string tag, input logic ld, input logic st,
                      input logic [VD-1:0] vi, input logic [CD-1:0] ci);
    @(negedge clk);
    compareNow();
    tagNow = tag;
    initLoad = ld; iterStrobe = st; varIn = vi; chkIn = ci;
  endtask

  task automatic idleScramble();
    @(negedge clk);
    compareNow();
    tagNow = "R9";
    initLoad = 1'b0; iterStrobe = 1'b0;
    chanBit = ~chanBit; varIn = ~varIn; chkIn = ~chkIn;
    flipThresh = flipThresh + 1'b1; useRuleB = ~useRuleB;
  endtask

  task automatic sweep(input logic ch);
    chanBit = ch;
    // R2: load wins over a simultaneous strobe
    step("R2", 1'b1, 1'b1, 3'b101, 6'b110011);
    chanBit = ~ch;
    useRuleB = 1'b0;
    for (int p = 0; p < 8; p++) begin
      step("R4", 1'b0, 1'b1, p[VD-1:0], CD'(p * 11 + 5));
      useRuleB = 1'b1; flipThresh = 3'd2; useRuleB = 1'b0;
    end
    idleScramble();
    useRuleB = 1'b1;
    for (int t = 0; t < 8; t++) begin
      flipThresh = t[TW-1:0];
      for (int p = 0; p < 8; p++) begin
        if (t == 0)      step("R7", 1'b0, 1'b1, p[VD-1:0], CD'(p * 7 + t));
        else if (t >= VD) step("R6", 1'b0, 1'b1, p[VD-1:0], CD'(p * 7 + t));
        else             step("R5", 1'b0, 1'b1, p[VD-1:0], CD'(p * 7 + t));
      end
    end
    for (int p = 0; p < 8; p++) step("R8", 1'b0, 1'b1, p[VD-1:0], CD'(63 - p));
    for (int p = 0; p < 8; p++) step("R3", 1'b0, 1'b1, p[VD-1:0], CD'(p * 8 + 1));
    idleScramble();
    idleScramble();
  endtask

  initial begin : watchdog
    #(5ns * 20000);
    mismatched++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compareNow();
    rst = 1'b0;
    tagNow = "R9";
    idleScramble();
    sweep(1'b1);
    sweep(1'b0);
    // R1: mid-run reset
    @(negedge clk);
    compareNow();
    tagNow = "R1";
    rst = 1'b1; iterStrobe = 1'b1;
    @(negedge clk);
    compareNow();
    rst = 1'b0; iterStrobe = 1'b0;
    step("R9", 1'b0, 1'b0, 3'b111, 6'b111111);
    @(negedge clk);
    compareNow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule